// File: doc/BRIEF.md
# Position-Strobe Payload Byte Source

This block feeds payload bytes to a SONET/SDH transmit framer that marks each coming byte slot with position strobes. A serial E3 bit stream arrives as one bit per cycle of a bit strobe. The block packs the bits into bytes and holds them in a 32-byte buffer. On each qualified slot that the framer marks as payload, it hands the oldest byte to the framer. Software turns the block on with a level enable. The block then waits for the path-overhead strobe before it gives out any payload.

While it runs, the block checks every row. From one path-overhead strobe to the next there must be exactly 90 qualified slots, and 84 of them must be payload. A row that breaks this rule sets a sticky pattern error and stops the block until software turns the enable off and on again. A buffer that overflows or underflows sets a second sticky error. One status-read strobe clears both errors.

The controller has four states. ST_IDLE is entered after reset or whenever the enable is low: the buffer and the packer are flushed. ST_HUNT waits for the path-overhead strobe. ST_RUN gives out payload and checks rows. ST_FAULT holds the output idle after a bad row. The transitions are:
- ENABLE (ST_IDLE to ST_HUNT) when the enable is high.
- LOCK (ST_HUNT to ST_RUN) on a qualified path-overhead slot.
- BREAK (ST_RUN to ST_FAULT) on a row error.
- DISABLE (any state to ST_IDLE) when the enable is low.

Top module: `mbus_payload_src`

## Requirements
- R1: On each cycle with `e3_bit_en` high, the block samples `e3_bit`. The first bit of each group of eight becomes bit 7 of the byte, so the bits are packed MSB first.
- R2: The buffer holds 32 bytes. A byte completed while the buffer is full, with no pop in the same cycle, is dropped and sets `fifo_corrupt`. The 32 bytes already held still come out in order.
- R3: While `enable` is 0, `tx_data` is 0xFF one cycle later and `synced` is 0. Bytes received in this state are discarded, and so is the content of the buffer.
- R4: After `enable` rises, payload strobes are ignored and `tx_data` stays 0xFF. This lasts until a qualified path-overhead slot. One cycle after that slot, `synced` is 1.
- R5: In ST_RUN, a qualified payload slot puts the oldest buffered byte on `tx_data` in the following cycle, and bytes leave in arrival order. Any other qualified or idle cycle with `slot_en` high puts 0xFF on `tx_data`.
- R6: The path-overhead strobe must be the 90th qualified slot after the previous one, and 84 slots in that span must be payload. It is also an error if a 90th slot arrives that is not path overhead. On an error, `sts_corrupt` is set, `synced` drops, and the output stays 0xFF until the enable is toggled.
- R7: A payload slot that finds the buffer empty gives 0xFF and sets `fifo_corrupt`.
- R8: Both error flags stay set until a cycle with `stat_rd` high. If an error and `stat_rd` occur in the same cycle, the flag stays set.
- R9: A cycle with `slot_en` low changes nothing on the slot side: there is no pop, no row count, and `tx_data` holds its value.
- R10: Strobes count only while `pos_val` is high. When several strobes are high, the slot type follows this priority: path overhead, then payload, then fixed overhead or frame pulse (both are non-payload). A payload strobe without `pos_val` pops nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset |
| enable | input | 1 | Software enable level |
| e3_bit_en | input | 1 | Serial bit strobe |
| e3_bit | input | 1 | Serial E3 data bit |
| slot_en | input | 1 | Framer clock enable |
| pos_val | input | 1 | Qualifies the position strobes |
| pos_pl | input | 1 | Next slot is payload |
| pos_foh | input | 1 | Next slot is fixed overhead |
| pos_poh | input | 1 | Next slot is path overhead |
| pos_fp | input | 1 | Frame pulse marker |
| stat_rd | input | 1 | Status read; clears both error flags |
| tx_data | output | 8 | Byte for the framer |
| synced | output | 1 | Aligned to path overhead (ST_RUN) |
| sts_corrupt | output | 1 | Sticky row-pattern error |
| fifo_corrupt | output | 1 | Sticky overflow or underflow error |

## Verification
The bound assertions check on every cycle:
- the 0xFF output while the block is disabled;
- that `synced` rises only after a qualified path-overhead slot and falls only on disable or a row error;
- that `tx_data` holds while `slot_en` is low;
- that both error flags stay sticky;
- that the buffer fill stays within bounds.

Only the bench scenarios can show the byte content and its order, the MSB-first packing, the drop of the overflow byte, the 0xFF given on underflow, and whether a 90-slot row with 84 payload slots passes while one with 83 is rejected.

// File: rtl/mps_pkg.sv
package mps_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HUNT,
        ST_RUN,
        ST_FAULT
    } mps_state_e;

    typedef enum logic [1:0] {
        SLOT_NONE,
        SLOT_PL,
        SLOT_OTHER,
        SLOT_POH
    } slot_kind_e;
endpackage

// File: rtl/e3_packer.sv
module e3_packer #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              bit_en,
    input  logic              bit_in,
    output logic              byte_vld,
    output logic [DATA_W-1:0] byte_out
);
    localparam int CW = $clog2(DATA_W);

    logic [DATA_W-2:0] shreg;
    logic [CW-1:0]     cnt;

    // The byte is handed over in the same cycle as its last bit.
    assign byte_vld = bit_en && (cnt == CW'(DATA_W - 1));
    assign byte_out = {shreg, bit_in};

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            shreg <= '0;
            cnt   <= '0;
        end else if (bit_en) begin
            shreg <= {shreg[DATA_W-3:0], bit_in};
            cnt   <= (cnt == CW'(DATA_W - 1)) ? '0 : cnt + 1'b1;
        end
    end
endmodule

// File: rtl/byte_fifo.sv
module byte_fifo #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr,
    input  logic                       push,
    input  logic [DATA_W-1:0]          din,
    input  logic                       pop,
    output logic [DATA_W-1:0]          dout,
    output logic                       empty,
    output logic                       full,
    output logic [$clog2(DEPTH):0]     fill
);
    localparam int AW = $clog2(DEPTH);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wr_ptr;
    logic [AW-1:0]     rd_ptr;
    logic              do_push;
    logic              do_pop;

    assign empty   = (fill == '0);
    assign full    = (fill == (AW+1)'(DEPTH));
    assign do_pop  = pop && !empty;
    assign do_push = push && (!full || do_pop);
    assign dout    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
            unique case ({do_push, do_pop})
                2'b10:   fill <= fill + 1'b1;
                2'b01:   fill <= fill - 1'b1;
                default: fill <= fill;
            endcase
        end
    end
endmodule

// File: rtl/slot_checker.sv
module slot_checker
    import mps_pkg::*;
#(
    parameter int ROW_SLOTS   = 90,
    parameter int ROW_PAYLOAD = 84
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       adv,
    input  slot_kind_e kind,
    output logic       bad
);
    localparam int CW = $clog2(ROW_SLOTS + 1);

    logic [CW-1:0] slot_cnt;
    logic [CW-1:0] pl_cnt;
    logic [CW-1:0] slots_nx;

    assign slots_nx = slot_cnt + 1'b1;

    always_comb begin
        bad = 1'b0;
        if (adv) begin
            if (kind == SLOT_POH) begin
                bad = (slots_nx != CW'(ROW_SLOTS)) || (pl_cnt != CW'(ROW_PAYLOAD));
            end else begin
                bad = (slots_nx >= CW'(ROW_SLOTS));
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr || (adv && kind == SLOT_POH)) begin
            slot_cnt <= '0;
            pl_cnt   <= '0;
        end else if (adv) begin
            slot_cnt <= slots_nx;
            if (kind == SLOT_PL) pl_cnt <= pl_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/mbus_payload_src.sv
module mbus_payload_src
    import mps_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int DEPTH       = 32,
    parameter int ROW_SLOTS   = 90,
    parameter int ROW_PAYLOAD = 84
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              e3_bit_en,
    input  logic              e3_bit,
    input  logic              slot_en,
    input  logic              pos_val,
    input  logic              pos_pl,
    input  logic              pos_foh,
    input  logic              pos_poh,
    input  logic              pos_fp,
    input  logic              stat_rd,
    output logic [DATA_W-1:0] tx_data,
    output logic              synced,
    output logic              sts_corrupt,
    output logic              fifo_corrupt
);
    localparam int FW = $clog2(DEPTH) + 1;
    localparam logic [DATA_W-1:0] IDLE_BYTE = '1;

    mps_state_e        state, state_nx;
    slot_kind_e        kind;
    logic              live;
    logic              flush;
    logic              byte_vld;
    logic [DATA_W-1:0] byte_val;
    logic              pop;
    logic [DATA_W-1:0] head;
    logic              empty;
    logic              full;
    logic [FW-1:0]     fill;
    logic              row_bad;
    logic              ovf;
    logic              unf;

    always_comb begin
        if (!pos_val)               kind = SLOT_NONE;
        else if (pos_poh)           kind = SLOT_POH;
        else if (pos_pl)            kind = SLOT_PL;
        else if (pos_foh || pos_fp) kind = SLOT_OTHER;
        else                        kind = SLOT_NONE;
    end

    assign live  = (state == ST_RUN) && enable;
    assign flush = (state == ST_IDLE);
    assign pop   = live && slot_en && (kind == SLOT_PL);
    assign ovf   = byte_vld && full && !pop;
    assign unf   = pop && empty;

    e3_packer #(.DATA_W(DATA_W)) u_pack (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (flush),
        .bit_en   (e3_bit_en),
        .bit_in   (e3_bit),
        .byte_vld (byte_vld),
        .byte_out (byte_val)
    );

    byte_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (flush),
        .push  (byte_vld),
        .din   (byte_val),
        .pop   (pop),
        .dout  (head),
        .empty (empty),
        .full  (full),
        .fill  (fill)
    );

    slot_checker #(.ROW_SLOTS(ROW_SLOTS), .ROW_PAYLOAD(ROW_PAYLOAD)) u_rowchk (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!live),
        .adv   (live && slot_en && (kind != SLOT_NONE)),
        .kind  (kind),
        .bad   (row_bad)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Transitions: ENABLE, LOCK, BREAK, DISABLE
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (enable) state_nx = ST_HUNT;
            ST_HUNT:  if (!enable) state_nx = ST_IDLE;
                      else if (slot_en && kind == SLOT_POH) state_nx = ST_RUN;
            ST_RUN:   if (!enable) state_nx = ST_IDLE;
                      else if (row_bad) state_nx = ST_FAULT;
            ST_FAULT: if (!enable) state_nx = ST_IDLE;
        endcase
    end

    assign synced = (state == ST_RUN);

    // Outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_data      <= IDLE_BYTE;
            sts_corrupt  <= 1'b0;
            fifo_corrupt <= 1'b0;
        end else begin
            if (!live)        tx_data <= IDLE_BYTE;
            else if (slot_en) tx_data <= (pop && !empty) ? head : IDLE_BYTE;

            if (row_bad)      sts_corrupt <= 1'b1;
            else if (stat_rd) sts_corrupt <= 1'b0;

            if (ovf || unf)   fifo_corrupt <= 1'b1;
            else if (stat_rd) fifo_corrupt <= 1'b0;
        end
    end
endmodule

// File: rtl/mps_checker.sv
module mps_checker #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 32
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   enable,
    input logic                   slot_en,
    input logic                   pos_val,
    input logic                   pos_poh,
    input logic                   stat_rd,
    input logic [DATA_W-1:0]      tx_data,
    input logic                   synced,
    input logic                   sts_corrupt,
    input logic                   fifo_corrupt,
    input logic [$clog2(DEPTH):0] fill
);
    AST_IDLE_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (tx_data == '1)); // R3
    AST_NO_SYNC_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !synced); // R3
    AST_SYNC_ON_POH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(synced) |-> $past(slot_en && pos_val && pos_poh)); // R4
    AST_SYNC_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(synced) |-> ($past(!enable) || sts_corrupt)); // R6
    AST_HOLD_NO_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && synced && !slot_en) |=> $stable(tx_data)); // R9
    AST_STS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_corrupt && !stat_rd) |=> sts_corrupt); // R8
    AST_FIFO_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_corrupt && !stat_rd) |=> fifo_corrupt); // R8
    AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= ($clog2(DEPTH)+1)'(DEPTH)); // R2
endmodule

bind mbus_payload_src mps_checker #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .enable       (enable),
    .slot_en      (slot_en),
    .pos_val      (pos_val),
    .pos_poh      (pos_poh),
    .stat_rd      (stat_rd),
    .tx_data      (tx_data),
    .synced       (synced),
    .sts_corrupt  (sts_corrupt),
    .fifo_corrupt (fifo_corrupt),
    .fill         (fill)
);

// File: tb/mbus_payload_src_tb.sv
module mbus_payload_src_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic       e3_bit_en = 1'b0;
    logic       e3_bit = 1'b0;
    logic       slot_en = 1'b0;
    logic       pos_val = 1'b0;
    logic       pos_pl = 1'b0;
    logic       pos_foh = 1'b0;
    logic       pos_poh = 1'b0;
    logic       pos_fp = 1'b0;
    logic       stat_rd = 1'b0;
    logic [7:0] tx_data;
    logic       synced;
    logic       sts_corrupt;
    logic       fifo_corrupt;

    int         n_chk = 0;
    int         n_fail = 0;
    logic [7:0] q[$];
    logic       m_run = 1'b0;
    logic       chk_pl = 1'b0;
    logic [7:0] prev;

    always #4 clk = ~clk;

    mbus_payload_src u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .e3_bit_en(e3_bit_en), .e3_bit(e3_bit),
        .slot_en(slot_en), .pos_val(pos_val), .pos_pl(pos_pl),
        .pos_foh(pos_foh), .pos_poh(pos_poh), .pos_fp(pos_fp),
        .stat_rd(stat_rd), .tx_data(tx_data), .synced(synced),
        .sts_corrupt(sts_corrupt), .fifo_corrupt(fifo_corrupt)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic put(input logic se, input logic v, input logic pl, input logic foh,
                       input logic poh, input logic ben, input logic b, input logic rd);
        @(negedge clk);
        slot_en = se; pos_val = v; pos_pl = pl; pos_foh = foh;
        pos_poh = poh; pos_fp = 1'b0; e3_bit_en = ben; e3_bit = b; stat_rd = rd;
    endtask

    task automatic idle();
        put(0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    // Driver: sends a byte MSB first, then records it as expected
    task automatic load_byte(input logic [7:0] b, input bit keep);
        for (int i = 7; i >= 0; i--) put(0, 0, 0, 0, 0, 1, b[i], 0);
        if (keep && q.size() < 32) q.push_back(b);
    endtask

    task automatic row(input int n_other, input int n_pl, input bit load);
        for (int i = 0; i < n_other; i++) put(1, 1, 0, 1, 0, 0, 0, 0);
        for (int i = 0; i < n_pl; i++) begin
            if (load) load_byte(8'(i * 37 + 11), 1'b1);
            put(1, 1, 1, 0, 0, 0, 0, 0);
        end
        put(1, 1, 0, 0, 1, 0, 0, 0);
    endtask

    // Monitor: payload slots taken in RUN are compared with the queue
    always @(posedge clk) chk_pl <= rst_n && slot_en && pos_val && pos_pl && !pos_poh && m_run;

    always @(negedge clk) begin
        if (chk_pl) begin
            logic [7:0] e;
            e = (q.size() > 0) ? q.pop_front() : 8'hFF;
            chk(tx_data == e, "R5 payload byte", 32'(tx_data), 32'(e));
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        idle();
        chk(tx_data == 8'hFF, "R3 reset data", 32'(tx_data), 32'hFF);
        chk(!synced && !sts_corrupt && !fifo_corrupt, "R3 reset flags",
            {29'd0, synced, sts_corrupt, fifo_corrupt}, 0);

        // Disabled: bits and strobes have no effect
        load_byte(8'h55, 1'b0);
        put(1, 1, 1, 0, 0, 0, 0, 0);
        idle();
        chk(tx_data == 8'hFF, "R3 disabled data", 32'(tx_data), 32'hFF);

        // Enable, hunt
        enable = 1'b1;
        idle();
        load_byte(8'hA5, 1'b1);
        load_byte(8'h3C, 1'b1);
        load_byte(8'h81, 1'b1);
        put(1, 1, 1, 0, 0, 0, 0, 0);
        idle();
        chk(tx_data == 8'hFF, "R4 hunt data", 32'(tx_data), 32'hFF);
        chk(!synced, "R4 hunt sync", 32'(synced), 0);
        put(1, 1, 0, 0, 1, 0, 0, 0);
        m_run = 1'b1;
        idle();
        chk(synced, "R4 lock", 32'(synced), 1);

        // Row A: one pop here plus 5 other, 83 payload, poh
        put(1, 1, 1, 0, 0, 0, 0, 0);
        idle();
        chk(tx_data == 8'hA5, "R1 msb first", 32'(tx_data), 32'hA5);
        row(5, 83, 1'b1);
        idle();
        chk(tx_data == 8'hFF, "R5 non-payload slot", 32'(tx_data), 32'hFF);
        chk(!sts_corrupt && synced, "R6 good row", {30'd0, sts_corrupt, synced}, 1);

        // R9: slot enable low holds data; R10: unqualified payload strobe
        put(1, 1, 1, 0, 0, 0, 0, 0);
        put(0, 1, 1, 0, 0, 0, 0, 0);
        prev = tx_data;
        idle();
        chk(tx_data == prev, "R9 hold", 32'(tx_data), 32'(prev));
        put(1, 0, 1, 0, 0, 0, 0, 0);
        idle();
        chk(tx_data == 8'hFF, "R10 unqualified", 32'(tx_data), 32'hFF);

        // Row B: drains buffer then underflows
        row(5, 83, 1'b0);
        idle();
        chk(fifo_corrupt, "R7 underflow flag", 32'(fifo_corrupt), 1);
        chk(!sts_corrupt, "R6 second row", 32'(sts_corrupt), 0);
        put(0, 0, 0, 0, 0, 0, 0, 1);
        idle();
        chk(!fifo_corrupt, "R8 clear fifo flag", 32'(fifo_corrupt), 0);

        // Row C: only 83 payload
        row(6, 83, 1'b1);
        m_run = 1'b0;
        idle();
        chk(sts_corrupt, "R6 bad row flag", 32'(sts_corrupt), 1);
        chk(!synced, "R6 sync lost", 32'(synced), 0);
        load_byte(8'h42, 1'b0);
        put(1, 1, 1, 0, 0, 0, 0, 0);
        idle();
        chk(tx_data == 8'hFF, "R6 fault output", 32'(tx_data), 32'hFF);
        repeat (3) idle();
        chk(sts_corrupt, "R8 sticky", 32'(sts_corrupt), 1);
        put(0, 0, 0, 0, 0, 0, 0, 1);
        idle();
        chk(!sts_corrupt, "R8 clear sts flag", 32'(sts_corrupt), 0);

        // Restart and overflow
        enable = 1'b0;
        q.delete();
        idle();
        idle();
        chk(tx_data == 8'hFF && !synced, "R3 restart", {23'd0, tx_data, synced}, 32'h1FE);
        enable = 1'b1;
        idle();
        for (int i = 0; i < 33; i++) load_byte(8'(i * 53 + 7), 1'b1);
        idle();
        chk(fifo_corrupt, "R2 overflow flag", 32'(fifo_corrupt), 1);
        chk(q.size() == 32, "R2 depth", 32'(q.size()), 32);
        put(1, 1, 0, 0, 1, 0, 0, 0);
        m_run = 1'b1;
        idle();
        chk(synced, "R4 relock", 32'(synced), 1);
        for (int i = 0; i < 33; i++) put(1, 1, 1, 0, 0, 0, 0, 0);
        idle();
        idle();
        chk(q.size() == 0, "R2 drained", 32'(q.size()), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule